// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Clear-to-Send Gating

This block sends characters on an asynchronous serial line. A holding buffer accepts one character from the register write port, and a separate shift register drives the line. When the shift register is free, or finishes its last stop bit, the buffered character moves across. Software can therefore queue the next character while the current one is still going out, and consecutive frames run with no idle gap between them. Each frame has a low start bit, 8 or 9 data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. A reloadable divider sets the bit time.

Two flags report progress: one for the holding buffer and one for the shift register. An interrupt request line can be set by either of these events, chosen by a select input, and it stays set until it is acknowledged. An optional active-low clear-to-send input is sampled only where a frame could start. It holds the line idle between frames and never shortens a frame that has already begun. Dropping the enable input has the same effect: the current frame finishes and no further frame starts. The frame configuration inputs are captured when a character moves into the shift register. They only need to be stable at that moment.

Top module: `uart_tx_dbuf`

## Requirements
- R1: One bit lasts exactly 16 × (n + 1) clock cycles, where n is `div_i`. The divider restarts when a frame starts, so the start bit has its full width. A character written into an idle transmitter starts its start bit on the second rising edge after the write cycle.
- R2: A frame is the start bit (0), then data bit 0 upward (8 bits, or 9 when `nine_bit_i` = 1), then a parity bit when `par_en_i` = 1, then one stop bit (1), or two when `two_stop_i` = 1.
- R3: The parity bit is the XOR of all data bits of the selected length, XORed with `par_odd_i`. This gives even parity when `par_odd_i` = 0 and odd parity when it is 1.
- R4: A write is accepted while `buf_empty_o` = 1. The character moves to the shift register when the transmitter is idle or on the final bit of the current frame, and `buf_empty_o` returns high at that moment. A queued character follows the previous stop bit with no idle cycle.
- R5: `shift_empty_o` is 0 while a frame is on the line. It becomes 1 after the last stop bit when no character starts next.
- R6: When `cts_en_i` = 1, a frame starts only while `cts_ni` = 0. While `cts_ni` = 1 the line stays idle with the character held in the buffer. Raising `cts_ni` during a frame does not shorten that frame.
- R7: While `en_i` = 0 no frame starts. A frame already in progress completes, and a buffered character stays held.
- R8: `txd_o` is 1 whenever no frame is being sent.
- R9: With `irq_sel_i` = 0, `irq_o` is set when a character leaves the buffer. With `irq_sel_i` = 1, it is set when the shift register becomes empty.
- R10: `irq_o` stays 1 until `irq_ack_i` is pulsed. A new interrupt event in the same cycle as the acknowledge keeps it set.
- R11: A write while `buf_empty_o` = 0 is discarded and sets `overrun_o`. The next accepted write clears `overrun_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock and divider count source |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Divider reload value n |
| en_i | input | 1 | Transmit enable |
| nine_bit_i | input | 1 | 1: 9 data bits, 0: 8 data bits |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| two_stop_i | input | 1 | 1: two stop bits, 0: one |
| cts_en_i | input | 1 | Enable clear-to-send gating |
| cts_ni | input | 1 | Clear-to-send, active low |
| irq_sel_i | input | 1 | Interrupt cause: 0 buffer empty, 1 shift register empty |
| irq_ack_i | input | 1 | Clear the interrupt request |
| wr_i | input | 1 | Write strobe for the buffer |
| wdata_i | input | 9 | Character to send |
| txd_o | output | 1 | Serial line |
| buf_empty_o | output | 1 | Holding buffer can accept a character |
| shift_empty_o | output | 1 | No frame on the line |
| overrun_o | output | 1 | A write was discarded |
| irq_o | output | 1 | Interrupt request |

## Verification
Frames are sent in plain 8-bit form, in 9-bit form with even parity and two stop bits, and with odd parity. Different data bytes in these modes separate bit order, length and parity errors. Two characters written back to back are timed from the first write to the final idle. This total exposes any gap between frames or any error in the bit width. A second divider value, together with a direct measurement of the start bit width, confirms the 16 × (n + 1) rule. Enable, clear-to-send and overrun are each tested by stalling a held character. The bench confirms that the line stays idle and that the correct character later appears: the first one written, not the one that was discarded.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_W  = 9;
  localparam int FRAME_W = 13;  // start + 9 data + parity + 2 stop
  localparam int OVS     = 16;  // ticks per bit

  typedef struct packed {
    logic nine;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } frame_cfg_t;
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 12,
  parameter int OVS   = uart_tx_pkg::OVS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             clear_i,
  input  logic             run_i,
  output logic             bit_end_o
);
  localparam int SUB_W = $clog2(OVS);

  logic [DIV_W-1:0] cnt_q;
  logic [SUB_W-1:0] sub_q;
  logic             tick;

  assign tick      = run_i && (cnt_q == '0);
  assign bit_end_o = tick && (sub_q == SUB_W'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sub_q <= '0;
    end else if (clear_i) begin
      cnt_q <= div_i;
      sub_q <= '0;
    end else if (run_i) begin
      if (tick) begin
        cnt_q <= div_i;
        sub_q <= (sub_q == SUB_W'(OVS - 1)) ? '0 : sub_q + 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  frame_cfg_t        cfg_i,
  input  logic              bit_end_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame, sr_q;
  logic [CNT_W-1:0]   nbits, left_q;
  logic               par;

  assign par = (^data_i[7:0]) ^ (cfg_i.nine & data_i[8]) ^ cfg_i.par_odd;

  always_comb begin
    int pos;
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++) frame[i+1] = data_i[i];
    pos = 9;
    if (cfg_i.nine) begin
      frame[9] = data_i[8];
      pos = 10;
    end
    if (cfg_i.par_en) begin
      frame[pos] = par;
      pos = pos + 1;
    end
    nbits = CNT_W'(pos + 1) + CNT_W'(cfg_i.two_stop);
  end

  assign done_o = busy_o && bit_end_i && (left_q == CNT_W'(1));
  assign txd_o  = busy_o ? sr_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      left_q <= '0;
      busy_o <= 1'b0;
    end else if (load_i) begin
      sr_q   <= frame;
      left_q <= nbits;
      busy_o <= 1'b1;
    end else if (busy_o && bit_end_i) begin
      sr_q   <= {1'b1, sr_q[FRAME_W-1:1]};
      left_q <= left_q - 1'b1;
      if (left_q == CNT_W'(1)) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             en_i,
  input  logic             nine_bit_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic             two_stop_i,
  input  logic             cts_en_i,
  input  logic             cts_ni,
  input  logic             irq_sel_i,
  input  logic             irq_ack_i,
  input  logic             wr_i,
  input  logic [8:0]       wdata_i,
  output logic             txd_o,
  output logic             buf_empty_o,
  output logic             shift_empty_o,
  output logic             overrun_o,
  output logic             irq_o
);
  logic [DATA_W-1:0] buf_q;
  logic              buf_full_q;
  logic              busy, done, bit_end, start, irq_ev;
  frame_cfg_t        cfg;

  assign cfg   = '{nine: nine_bit_i, par_en: par_en_i,
                   par_odd: par_odd_i, two_stop: two_stop_i};
  // start only at a frame boundary; CTS is not looked at mid-frame
  assign start = buf_full_q && en_i && (!cts_en_i || !cts_ni) && (!busy || done);
  assign irq_ev = irq_sel_i ? (done && !start) : start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q      <= '0;
      buf_full_q <= 1'b0;
      overrun_o  <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      if (wr_i && !buf_full_q) begin
        buf_q      <= wdata_i;
        buf_full_q <= 1'b1;
        overrun_o  <= 1'b0;
      end else if (wr_i) begin
        overrun_o  <= 1'b1;
      end
      if (start) buf_full_q <= 1'b0;
      irq_o <= irq_ev || (irq_o && !irq_ack_i);
    end
  end

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_i    (div_i),
    .clear_i  (start),
    .run_i    (busy),
    .bit_end_o(bit_end)
  );

  uart_tx_shift u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start),
    .data_i   (buf_q),
    .cfg_i    (cfg),
    .bit_end_i(bit_end),
    .txd_o    (txd_o),
    .busy_o   (busy),
    .done_o   (done)
  );

  assign buf_empty_o   = !buf_full_q;
  assign shift_empty_o = !busy;
endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic cts_en_i,
  input logic cts_ni,
  input logic irq_sel_i,
  input logic irq_ack_i,
  input logic wr_i,
  input logic txd_o,
  input logic buf_empty_o,
  input logic shift_empty_o,
  input logic overrun_o,
  input logic irq_o
);
  // R8
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_empty_o |-> txd_o);
  // R11
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !buf_empty_o |=> overrun_o);
  // R10
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_ack_i |=> irq_o);
  // R7
  no_start_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && shift_empty_o |=> shift_empty_o);
  // R6
  cts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cts_en_i && cts_ni && shift_empty_o |=> shift_empty_o);
  // R4
  buf_to_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_empty_o) |-> !shift_empty_o);
  // R5
  last_bit_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shift_empty_o) |-> $past(txd_o));
  // R9
  irq_bufev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_empty_o) && $past(!irq_sel_i) |-> irq_o);
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk u_chk (.*);

// File: tb/sim_uart_tx_dbuf.sv
module sim_uart_tx_dbuf;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic en = 1'b1, nine = 1'b0, pe = 1'b0, odd = 1'b0, two = 1'b0;
  logic cts_en = 1'b0, cts_n = 1'b0, isel = 1'b0, ack = 1'b0, wr = 1'b0;
  logic [8:0]  wdata = '0;
  logic [11:0] div = '0;
  logic txd, be, se, ovr, irq;
  int   n_tests = 0, n_fail = 0;
  bit   finished = 0;
  logic [12:0] q_bits[$];
  int          q_len[$];

  always #10 clk = ~clk;  // 50 MHz

  uart_tx_dbuf u0 (
    .clk_i(clk), .rst_ni(rst_ni), .div_i(div), .en_i(en),
    .nine_bit_i(nine), .par_en_i(pe), .par_odd_i(odd), .two_stop_i(two),
    .cts_en_i(cts_en), .cts_ni(cts_n), .irq_sel_i(isel), .irq_ack_i(ack),
    .wr_i(wr), .wdata_i(wdata), .txd_o(txd), .buf_empty_o(be),
    .shift_empty_o(se), .overrun_o(ovr), .irq_o(irq));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic write_raw(input logic [8:0] d);
    wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // driver: push expected frame, then write
  task automatic send(input logic [8:0] d);
    logic [12:0] f;
    int p;
    f = '1; f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = d[i];
    p = 9;
    if (nine) begin f[9] = d[8]; p = 10; end
    if (pe) begin
      f[p] = (^d[7:0]) ^ (nine & d[8]) ^ odd;
      p++;
    end
    q_bits.push_back(f);
    q_len.push_back(p + 1 + int'(two));
    write_raw(d);
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (!se) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  // monitor: sample mid-bit, pop and compare
  initial begin
    int bt, len;
    logic [12:0] got, e, m;
    wait (rst_ni);
    forever begin
      @(negedge clk);
      if (txd == 1'b0) begin
        if (q_len.size() == 0) begin
          chk(0, "R2", "unexpected frame", 0, 1);
          while (txd == 1'b0) @(negedge clk);
        end else begin
          bt = 16 * (int'(div) + 1);
          len = q_len.pop_front();
          e = q_bits.pop_front();
          got = '1;
          repeat (bt/2 - 1) @(negedge clk);
          got[0] = txd;
          for (int i = 1; i < len; i++) begin
            repeat (bt) @(negedge clk);
            got[i] = txd;
          end
          m = (13'h1 << len) - 13'h1;
          chk(((got ^ e) & m) == '0, "R2/R3", "frame bits", int'(got & m), int'(e & m));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R8", "reset txd", txd, 1);
    chk(be == 1'b1, "R4", "reset buf_empty", be, 1);
    chk(se == 1'b1, "R5", "reset shift_empty", se, 1);
    chk(irq == 1'b0 && ovr == 1'b0, "R10", "reset irq/ovr", irq, 0);

    // back-to-back 8N1, irq on buffer empty
    send(9'h0A5); cnt = 1;
    @(negedge clk); @(negedge clk); cnt = 3;
    chk(be == 1'b1, "R4", "buffer free while shifting", be, 1);
    chk(se == 1'b0, "R5", "shift busy", se, 0);
    chk(irq == 1'b1, "R9", "irq on buffer empty", irq, 1);
    send(9'h03C); cnt++;
    while (!se) begin @(negedge clk); cnt++; end
    chk(cnt == 322, "R1", "two frames total cycles (R4 no gap)", cnt, 322);
    chk(irq == 1'b1, "R10", "irq held", irq, 1);
    pulse_ack();
    chk(irq == 1'b0, "R10", "irq cleared by ack", irq, 0);

    // 9-bit, even parity, two stops; then odd parity
    nine = 1'b1; pe = 1'b1; two = 1'b1;
    send(9'h1A3); wait_idle();
    send(9'h0FF); wait_idle();
    odd = 1'b1; two = 1'b0;
    send(9'h155); wait_idle();
    nine = 1'b0;
    send(9'h0C4); wait_idle();
    pe = 1'b0; odd = 1'b0;

    // divider n=2: start bit width
    div = 12'd2;
    send(9'h001);
    while (txd) @(negedge clk);
    cnt = 0;
    while (!txd) begin @(negedge clk); cnt++; end
    chk(cnt == 48, "R1", "start bit cycles n=2", cnt, 48);
    wait_idle();
    div = 12'd0;

    // enable off with overrun
    en = 1'b0;
    send(9'h011);
    write_raw(9'h022);
    chk(ovr == 1'b1, "R11", "overrun set", ovr, 1);
    repeat (100) @(negedge clk);
    chk(txd == 1'b1 && se == 1'b1, "R7", "no frame while disabled", se, 1);
    chk(be == 1'b0, "R7", "char held", be, 0);
    en = 1'b1;
    wait_idle();
    send(9'h033);
    chk(ovr == 1'b0, "R11", "overrun cleared by accepted write", ovr, 0);
    wait_idle();

    // disable mid-frame
    send(9'h044);
    repeat (20) @(negedge clk);
    send(9'h055);
    en = 1'b0;
    wait_idle();
    repeat (50) @(negedge clk);
    chk(se == 1'b1 && be == 1'b0, "R7", "frame finished, next held", be, 0);
    en = 1'b1;
    wait_idle();

    // CTS gating
    cts_en = 1'b1; cts_n = 1'b1;
    send(9'h066);
    repeat (80) @(negedge clk);
    chk(se == 1'b1 && txd == 1'b1, "R6", "held by cts high", se, 1);
    chk(be == 1'b0, "R6", "char waits in buffer", be, 0);
    cts_n = 1'b0;
    repeat (30) @(negedge clk);
    cts_n = 1'b1;
    send(9'h077);
    wait_idle();
    repeat (40) @(negedge clk);
    chk(se == 1'b1 && be == 1'b0, "R6", "next frame held at boundary", be, 0);
    cts_n = 1'b0;
    wait_idle();
    cts_en = 1'b0;

    // irq on shift empty
    pulse_ack();
    isel = 1'b1;
    send(9'h088);
    repeat (60) @(negedge clk);
    chk(irq == 1'b0, "R9", "no irq mid-frame (sel=1)", irq, 0);
    wait_idle();
    @(negedge clk);
    chk(irq == 1'b1, "R9", "irq on transmit complete", irq, 1);
    repeat (20) @(negedge clk);
    chk(irq == 1'b1, "R10", "irq sticky", irq, 1);
    pulse_ack();
    chk(irq == 1'b0, "R10", "irq ack", irq, 0);
    chk(txd == 1'b1, "R8", "idle high at end", txd, 1);

    repeat (20) @(negedge clk);
    chk(q_len.size() == 0, "R2", "all frames seen", q_len.size(), 0);
    report();
  end
endmodule